// File: doc/BRIEF.md
# Math Coprocessor Host Interface Controller

This block is the host-side front end of a stack-oriented arithmetic coprocessor. A host processor talks to it over an 8-bit bus using an active-low chip select, a register-select line, and active-low read and write strobes. With the select line low, the host moves operand bytes to and from the operand stack. With the select line high, it writes command bytes or reads the status byte.

A command byte starts a busy period in a sequencer. During that period a stub execution unit stands in for the arithmetic engine. It holds the block busy for a cycle count that depends on the opcode, then hands back result flags. When the command completes, the controller drives an active-low completion line and, if the command asked for it, raises a service-request line. Any operand or command access attempted while busy is held off by pulling READY low, and it goes through once execution ends.

All bus inputs pass through two-flop synchronizers. A write or read takes effect once, at the end of its strobe, however long the strobe is held.

Top module: `copro_host_ctrl`

## Requirements
- R1: With chip select low and the select line low, the end of a write strobe pushes the byte captured during the strobe (`stack_push_o` high for one clock with the byte on `stack_wdata_o`). The end of a read strobe pops (`stack_pop_o` high for one clock), and during that read `data_o` carries `stack_rdata_i`. With chip select high, no push, pop or command takes place.
- R2: `data_oe_o` is high only while both chip select and read are low. A read with the select line high returns the status byte.
- R3: A strobe held low for many clocks causes exactly one action.
- R4: The status byte holds BUSY in bit 7, SIGN in bit 6, ZERO in bit 5, the error code in bits 4:1 and CARRY in bit 0. BUSY reads 1 while a command is executing.
- R5: Command bits 4:0 pick the opcode. The latency L is 17 for opcode 0x0C, 12 for 0x18, 1 for 0x00 and 8 for every other opcode. END falls on the (L+3)th rising clock edge after the command write strobe ends.
- R6: Stub result flags on completion are: SIGN = opcode bit 4; ZERO = 1 when opcode bits 3:0 are 0; CARRY = opcode bit 0. The error code is 0100 for opcode 0x01, 1100 for 0x05 and 0x06, and 0000 otherwise. BUSY reads 0 afterwards.
- R7: END stays low after completion until EACK goes low or any bus access starts. With EACK held low, END is low for exactly one clock.
- R8: At completion, SVREQ takes the value of bit 7 of the command. It then holds until SVACK goes low or the next command completes.
- R9: READY is low while busy and an operand or command access is active. A status read is never stalled. A stalled write completes once execution ends.
- R10: Reset aborts a running command and leaves the status byte 0x00, END high, SVREQ low and READY high. No completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| a0_i | input | 1 | Register select: 0 operand stack, 1 command/status |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_i | input | 8 | Bus write data |
| data_o | output | 8 | Bus read data |
| data_oe_o | output | 1 | Bus drive enable |
| ready_o | output | 1 | High when the bus access may complete |
| end_no | output | 1 | Completion flag, active low |
| eack_ni | input | 1 | Completion acknowledge, active low |
| svreq_o | output | 1 | Service request |
| svack_ni | input | 1 | Service acknowledge, active low |
| stack_push_o | output | 1 | One-clock push strobe to operand stack |
| stack_pop_o | output | 1 | One-clock pop strobe to operand stack |
| stack_wdata_o | output | 8 | Byte to push |
| stack_rdata_i | input | 8 | Byte at top of operand stack |

## Verification
A table of command bytes drives the main path, covering every latency class and every error-code class, with bit 7 both set and clear. The exact cycle of END separates the latency classes. The status byte separates the flag encodings. SVREQ shows whether bit 7 was carried through.

Directed patterns cover the following:
- A write held against a busy unit, which shows stalling rather than dropping.
- EACK tied low, which must produce a one-clock END pulse.
- A status read after completion, which must clear END.
- Strobes with chip select high, which must have no effect.
- A long-held write, which must act once.
- A reset in mid-command, which must never complete.

// File: rtl/copro_pkg.sv
package copro_pkg;
  localparam int OP_W  = 5;
  localparam int LAT_W = 8;

  typedef struct packed {
    logic       sign;
    logic       zero;
    logic [3:0] err;
    logic       carry;
  } flags_t;

  typedef struct packed {
    logic   busy;
    flags_t flags;
  } status_t;

  function automatic logic [LAT_W-1:0] op_latency(input logic [OP_W-1:0] op);
    case (op)
      5'h0C:   op_latency = LAT_W'(17);
      5'h18:   op_latency = LAT_W'(12);
      5'h00:   op_latency = LAT_W'(1);
      default: op_latency = LAT_W'(8);
    endcase
  endfunction

  function automatic flags_t op_flags(input logic [OP_W-1:0] op);
    flags_t f;
    f.sign  = op[4];
    f.zero  = (op[3:0] == 4'h0);
    f.carry = op[0];
    case (op)
      5'h01:        f.err = 4'b0100;
      5'h05, 5'h06: f.err = 4'b1100;
      default:      f.err = 4'b0000;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/copro_bus_sync.sv
module copro_bus_sync #(
  parameter int         W       = 6,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/copro_exec_stub.sv
module copro_exec_stub
  import copro_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] op_i,
  output logic            done_o,
  output flags_t          flags_o
);
  logic [OP_W-1:0]  op_q;
  logic [LAT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      op_q  <= op_i;
      cnt_q <= op_latency(op_i);
      run_q <= 1'b1;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == LAT_W'(1)) run_q <= 1'b0;
    end
  end

  assign done_o  = run_q && (cnt_q == LAT_W'(1));
  assign flags_o = op_flags(op_q);

  // R5
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q);
endmodule

// File: rtl/copro_seq.sv
module copro_seq
  import copro_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_wr_i,
  input  logic [7:0]      cmd_i,
  input  logic            access_start_i,
  input  logic            eack_s_ni,
  input  logic            svack_s_ni,
  input  logic            done_i,
  input  flags_t          flags_i,
  output logic            start_o,
  output logic [OP_W-1:0] op_o,
  output status_t         status_o,
  output logic            end_no,
  output logic            svreq_o
);
  logic       busy_q;
  flags_t     flags_q;
  logic       svc_q;
  logic [OP_W-1:0] op_q;

  assign start_o = cmd_wr_i && !busy_q;
  assign op_o    = cmd_i[OP_W-1:0];

  // command register survives reset
  always_ff @(posedge clk_i) begin
    if (start_o) begin
      svc_q <= cmd_i[7];
      op_q  <= cmd_i[OP_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      flags_q <= '0;
      end_no  <= 1'b1;
      svreq_o <= 1'b0;
    end else begin
      if (start_o)     busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;

      if (done_i) flags_q <= flags_i;

      if (done_i)                             end_no <= 1'b0;
      else if (access_start_i || !eack_s_ni)  end_no <= 1'b1;

      if (done_i)           svreq_o <= svc_q;
      else if (!svack_s_ni) svreq_o <= 1'b0;
    end
  end

  assign status_o = '{busy: busy_q, flags: flags_q};

  // R4
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> busy_q);
  // R7
  end_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(end_no) |-> $past(done_i));
  // R7
  end_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_start_i && !done_i) |=> end_no);
  // R8
  svreq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(svreq_o) |-> $past(done_i));

  logic unused_op;
  assign unused_op = ^op_q;
endmodule

// File: rtl/copro_host_ctrl.sv
module copro_host_ctrl
  import copro_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              a0_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              ready_o,
  output logic              end_no,
  input  logic              eack_ni,
  output logic              svreq_o,
  input  logic              svack_ni,
  output logic              stack_push_o,
  output logic              stack_pop_o,
  output logic [DATA_W-1:0] stack_wdata_o,
  input  logic [DATA_W-1:0] stack_rdata_i
);
  localparam int NSYNC = 6;

  logic [NSYNC-1:0] sync_q;
  logic cs_s_n, a0_s, rd_s_n, wr_s_n, eack_s_n, svack_s_n;

  copro_bus_sync #(.W(NSYNC), .RST_VAL(6'b101111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, a0_i, rd_ni, wr_ni, eack_ni, svack_ni}),
    .q_o   (sync_q)
  );
  assign {cs_s_n, a0_s, rd_s_n, wr_s_n, eack_s_n, svack_s_n} = sync_q;

  logic sel_rd, sel_wr, sel_any;
  logic sel_rd_q, sel_wr_q, sel_any_q, a0_q;
  logic [DATA_W-1:0] din_q;
  logic rd_end, wr_end, access_start;

  assign sel_rd  = !cs_s_n && !rd_s_n;
  assign sel_wr  = !cs_s_n && !wr_s_n;
  assign sel_any = sel_rd || sel_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_rd_q  <= 1'b0;
      sel_wr_q  <= 1'b0;
      sel_any_q <= 1'b0;
      a0_q      <= 1'b0;
      din_q     <= '0;
    end else begin
      sel_rd_q  <= sel_rd;
      sel_wr_q  <= sel_wr;
      sel_any_q <= sel_any;
      if (sel_any) a0_q  <= a0_s;
      if (sel_wr)  din_q <= data_i;
    end
  end

  // actions fire once, when the strobe ends
  assign rd_end       = sel_rd_q && !sel_rd;
  assign wr_end       = sel_wr_q && !sel_wr;
  assign access_start = sel_any && !sel_any_q;

  status_t         status;
  flags_t          flags;
  logic            busy, start, done;
  logic [OP_W-1:0] op;

  assign busy = status.busy;

  copro_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_wr_i      (wr_end && a0_q),
    .cmd_i         (din_q[7:0]),
    .access_start_i(access_start),
    .eack_s_ni     (eack_s_n),
    .svack_s_ni    (svack_s_n),
    .done_i        (done),
    .flags_i       (flags),
    .start_o       (start),
    .op_o          (op),
    .status_o      (status),
    .end_no        (end_no),
    .svreq_o       (svreq_o)
  );

  copro_exec_stub u_exec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .op_i   (op),
    .done_o (done),
    .flags_o(flags)
  );

  assign stack_push_o  = wr_end && !a0_q && !busy;
  assign stack_pop_o   = rd_end && !a0_q && !busy;
  assign stack_wdata_o = din_q;

  // status reads pass while busy; stack and command accesses wait
  assign ready_o   = !(busy && (sel_wr || (sel_rd && !a0_s)));
  assign data_oe_o = !cs_ni && !rd_ni;
  assign data_o    = a0_i ? DATA_W'(status) : stack_rdata_i;

  // R3
  single_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_push_o |=> !stack_push_o);
  // R9
  ready_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && sel_any) |-> $fell(busy));
endmodule

// File: tb/sim_copro_host_ctrl.sv
`timescale 1ns/1ps
module sim_copro_host_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, a0_i = 1'b0, rd_ni = 1'b1, wr_ni = 1'b1;
  logic eack_ni = 1'b1, svack_ni = 1'b1;
  logic [7:0] data_i = '0, stack_rdata_i = 8'hA5;
  logic [7:0] data_o, stack_wdata_o;
  logic data_oe_o, ready_o, end_no, svreq_o, stack_push_o, stack_pop_o;

  int checks = 0, errors = 0;
  int push_cnt = 0, pop_cnt = 0;
  logic [7:0] last_push = '0;

  always #2.5 clk = ~clk;

  copro_host_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .a0_i(a0_i), .rd_ni(rd_ni),
    .wr_ni(wr_ni), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .ready_o(ready_o), .end_no(end_no), .eack_ni(eack_ni), .svreq_o(svreq_o),
    .svack_ni(svack_ni), .stack_push_o(stack_push_o), .stack_pop_o(stack_pop_o),
    .stack_wdata_o(stack_wdata_o), .stack_rdata_i(stack_rdata_i)
  );

  always @(negedge clk) begin
    if (stack_push_o) begin push_cnt++; last_push = stack_wdata_o; end
    if (stack_pop_o) pop_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a0, input logic [7:0] d);
    @(negedge clk);
    cs_ni = 0; a0_i = a0; data_i = d; wr_ni = 0;
    repeat (4) @(negedge clk);
    while (!ready_o) @(negedge clk);
    wr_ni = 1; cs_ni = 1;
  endtask

  task automatic bus_read(input logic a0, output logic [7:0] d, output logic oe);
    @(negedge clk);
    cs_ni = 0; a0_i = a0; rd_ni = 0;
    repeat (3) @(negedge clk);
    while (!ready_o) @(negedge clk);
    d = data_o; oe = data_oe_o;
    rd_ni = 1; cs_ni = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cycles from strobe release to END low
  task automatic measure_end(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (end_no && n < 100);
  endtask

  // {command, latency, expected status}
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {8'h0C, 8'd17, 8'h00},
    {8'h98, 8'd12, 8'h40},
    {8'h00, 8'd1,  8'h20},
    {8'h01, 8'd8,  8'h09},
    {8'h85, 8'd8,  8'h19},
    {8'h06, 8'd8,  8'h18},
    {8'h93, 8'd8,  8'h41},
    {8'h10, 8'd8,  8'h60}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    int n, p0, lowc;
    idle(3);
    rst_ni = 1;
    idle(4);
    // R10 reset state
    chk("R10 end", end_no, 1);
    chk("R10 svreq", svreq_o, 0);
    chk("R10 ready", ready_o, 1);
    bus_read(1, d, oe);
    chk("R10 status", d, 8'h00);
    chk("R2 oe on status read", oe, 1);

    for (int i = 0; i < NV; i++) begin
      bus_write(1, VEC[i][23:16]);
      measure_end(n);
      chk("R5 latency", n, VEC[i][15:8] + 3);
      chk("R8 svreq follows bit 7", svreq_o, VEC[i][23]);
      bus_read(1, d, oe);
      chk("R6 R4 status", d, VEC[i][7:0]);
      chk("R7 END cleared by read", end_no, 1);
    end

    // R8 svack clears
    bus_write(1, 8'h80); measure_end(n);
    chk("R8 svreq set", svreq_o, 1);
    idle(5);
    chk("R8 svreq held", svreq_o, 1);
    svack_ni = 0; idle(1); svack_ni = 1; idle(4);
    chk("R8 svack clears", svreq_o, 0);

    // R1 push and pop
    p0 = push_cnt;
    bus_write(0, 8'h3C); idle(4);
    chk("R1 push count", push_cnt, p0 + 1);
    chk("R1 push data", last_push, 8'h3C);
    p0 = pop_cnt;
    bus_read(0, d, oe);
    chk("R1 pop data", d, 8'hA5);
    chk("R1 pop count", pop_cnt, p0 + 1);

    // R1 R2 chip select high ignored
    p0 = push_cnt;
    @(negedge clk); a0_i = 0; wr_ni = 0; rd_ni = 0; data_i = 8'h77;
    idle(6);
    chk("R2 no drive with cs high", data_oe_o, 0);
    wr_ni = 1; rd_ni = 1; idle(5);
    chk("R1 cs high no push", push_cnt, p0);

    // R3 held strobe acts once
    p0 = push_cnt;
    @(negedge clk); cs_ni = 0; a0_i = 0; data_i = 8'h5A; wr_ni = 0;
    idle(20);
    wr_ni = 1; cs_ni = 1; idle(5);
    chk("R3 single push", push_cnt, p0 + 1);

    // R4 busy visible mid-command, status read not stalled
    bus_write(1, 8'h0C);
    bus_read(1, d, oe);
    chk("R4 busy bit", d[7], 1);
    measure_end(n);
    bus_read(1, d, oe);

    // R9 stall push while busy
    bus_write(1, 8'h0C);
    p0 = push_cnt;
    @(negedge clk); cs_ni = 0; a0_i = 0; data_i = 8'hC3; wr_ni = 0;
    idle(4);
    chk("R9 ready low while busy", ready_o, 0);
    n = 0;
    while (!ready_o && n < 50) begin @(negedge clk); n++; end
    chk("R9 ready returns", ready_o, 1);
    wr_ni = 1; cs_ni = 1; idle(5);
    chk("R9 stalled push done", push_cnt, p0 + 1);
    chk("R9 stalled push data", last_push, 8'hC3);
    bus_read(1, d, oe);

    // R7 END held until access
    bus_write(1, 8'h00); measure_end(n);
    idle(5);
    chk("R7 END held", end_no, 0);
    eack_ni = 0; idle(1); eack_ni = 1; idle(4);
    chk("R7 EACK clears END", end_no, 1);

    // R7 pulse mode
    eack_ni = 0; idle(4);
    bus_write(1, 8'h00);
    lowc = 0;
    for (int k = 0; k < 15; k++) begin @(negedge clk); if (!end_no) lowc++; end
    chk("R7 one-clock pulse", lowc, 1);
    eack_ni = 1; idle(4);

    // R10 reset aborts
    bus_write(1, 8'h0C);
    idle(5);
    rst_ni = 0; idle(1); rst_ni = 1; idle(4);
    chk("R10 end after abort", end_no, 1);
    chk("R10 ready after abort", ready_o, 1);
    chk("R10 svreq after abort", svreq_o, 0);
    bus_read(1, d, oe);
    chk("R10 status after abort", d, 8'h00);
    lowc = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (!end_no) lowc++; end
    chk("R10 no completion", lowc, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule